// File: doc/BRIEF.md
# Rewindable Parity-Width FIFO Buffer

This block is a single-clock first-in first-out store for 9-bit words, 2048 entries deep by default. A word is nine bits wide so that a parity bit can travel with each byte. It keeps its own write and read positions, so a producer only pulses a write strobe with a word, and a consumer only pulses a read strobe. Status outputs report when the store is empty, when it is full, and when it is more than half occupied. The enable strobes are sampled on the rising clock edge.

A rewind input moves reading back to the first word written since reset, without touching the write side. A link layer can use it to send a packet again after the far end reports an error. A rewind only makes sense while the store has never wrapped, meaning no more than DEPTH words have been written since reset. The block counts writes since reset. A rewind asked for after more than DEPTH writes is refused, and the block flags the refusal. The depth must be a power of two.

Top module: `rt_fifo`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `empty` is 1, and `full`, `half_full`, `rd_valid` and `rt_err` are 0. Both positions return to location zero.
- R2: A write is accepted only when `wr_en` is 1, `full` is 0 and `rt_req` is 0. A write request while full leaves the stored contents and the write position unchanged.
- R3: A read is accepted only when `rd_en` is 1, `empty` is 0 and `rt_req` is 0. A read request while empty produces no `rd_valid` pulse and does not move the read position.
- R4: `empty` is 1 exactly when no unread words remain, that is when the write count minus the read count is zero.
- R5: Starting from reset with no reads, `full` rises after exactly DEPTH accepted writes and not before.
- R6: `half_full` is 1 whenever occupancy exceeds DEPTH/2. It rises on the write that takes occupancy to DEPTH/2+1 and falls on the read that brings it back to DEPTH/2.
- R7: An accepted rewind sets the read position to location zero and leaves the write position alone. The flags follow the new occupancy, which equals the number of writes since reset, so a rewind after DEPTH writes shows `full` = 1.
- R8: When `rt_req` is 1 after more than DEPTH writes since reset, the rewind is ignored: the read position is unchanged, and `rt_err` is 1 for the one cycle after the request.
- R9: When `rt_req` is 1 in the same cycle as `wr_en` or `rd_en`, those requests are dropped, whether or not the rewind itself is accepted.
- R10: Words come out in write order. `rd_data` carries the word, with `rd_valid` at 1, in the cycle after the accepted read and only then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request strobe |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read request strobe |
| rt_req | input | 1 | Rewind request: restart reading at the first word |
| rd_data | output | 9 | Word read out |
| rd_valid | output | 1 | `rd_data` holds a newly read word |
| empty | output | 1 | No unread words |
| full | output | 1 | DEPTH unread words held |
| half_full | output | 1 | More than DEPTH/2 unread words held |
| rt_err | output | 1 | Previous rewind request was refused |

## Verification
Several functions can fall in the same cycle. The one that matters most is a rewind arriving together with a write or a read strobe: the rewind takes priority and the strobe must be lost. The bench raises `rt_req` with `wr_en` alone, and also with both `wr_en` and `rd_en`, and then drains the buffer. It judges the outcome from the words that come out and from the cycle in which `empty` rises: the word offered with the rewind must never appear, and the drain must replay exactly the words stored before it. A write into an empty buffer together with a read is also tested. In that case the write lands, the read is refused, and no valid pulse appears.

// File: rtl/rtfifo_pkg.sv
`timescale 1ns/1ps
package rtfifo_pkg;

    typedef struct packed {
        logic wr;
        logic rd;
        logic rt;
    } fifo_req_t;

    typedef enum logic [1:0] {
        RT_NONE   = 2'd0,
        RT_REWIND = 2'd1,
        RT_REJECT = 2'd2
    } rt_action_e;

    // Pointer width: address bits plus one wrap bit
    function automatic int unsigned ptr_bits(input int unsigned depth);
        return $clog2(depth) + 1;
    endfunction

    // Width able to count up to depth+1 writes
    function automatic int unsigned cnt_bits(input int unsigned depth);
        return $clog2(depth + 2);
    endfunction

endpackage

// File: rtl/rtfifo_mem.sv
`timescale 1ns/1ps
module rtfifo_mem #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned WIDTH = 9,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= store[raddr];
        end
    end

endmodule

// File: rtl/rtfifo_flags.sv
`timescale 1ns/1ps
module rtfifo_flags
    import rtfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned PW   = ptr_bits(DEPTH),
    localparam int unsigned HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] wr_ptr,
    input  logic [PW-1:0] rd_ptr,
    output logic          empty,
    output logic          full,
    output logic          half_full
);

    logic [PW-1:0] occ;

    always_comb begin
        occ       = wr_ptr - rd_ptr;
        empty     = (occ == '0);
        full      = (occ == PW'(DEPTH));
        half_full = (occ > PW'(HALF));
    end

    // R4
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    // R6
    half_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        half_full |-> !empty);

endmodule

// File: rtl/rtfifo_ctrl.sv
`timescale 1ns/1ps
module rtfifo_ctrl
    import rtfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned PW   = ptr_bits(DEPTH),
    localparam int unsigned CW   = cnt_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  fifo_req_t     req,
    input  logic          empty,
    input  logic          full,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic          wr_go,
    output logic          rd_go,
    output logic          rt_err
);

    localparam logic [CW-1:0] CNT_SAT = CW'(DEPTH + 1);

    logic [CW-1:0] wr_count;
    rt_action_e    rt_act;

    always_comb begin
        wr_go = req.wr && !req.rt && !full;
        rd_go = req.rd && !req.rt && !empty;
        if (!req.rt) begin
            rt_act = RT_NONE;
        end else if (wr_count <= CW'(DEPTH)) begin
            rt_act = RT_REWIND;
        end else begin
            rt_act = RT_REJECT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            wr_count <= '0;
            rt_err   <= 1'b0;
        end else begin
            if (wr_go) begin
                wr_ptr <= wr_ptr + 1'b1;
                if (wr_count != CNT_SAT) begin
                    wr_count <= wr_count + 1'b1;
                end
            end
            if (rt_act == RT_REWIND) begin
                rd_ptr <= '0;
            end else if (rd_go) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            rt_err <= (rt_act == RT_REJECT);
        end
    end

    // R2
    wr_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (req.wr && full) |=> $stable(wr_ptr));

    // R3
    rd_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (req.rd && empty && !req.rt) |=> $stable(rd_ptr));

    // R9
    rt_priority_chk: assert property (@(posedge clk) disable iff (rst)
        req.rt |=> $stable(wr_ptr));

    // R8
    rt_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rt_err |-> $past(req.rt));

endmodule

// File: rtl/rt_fifo.sv
`timescale 1ns/1ps
module rt_fifo
    import rtfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned WIDTH = 9,
    localparam int unsigned PW   = ptr_bits(DEPTH),
    localparam int unsigned AW   = PW - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rt_req,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             empty,
    output logic             full,
    output logic             half_full,
    output logic             rt_err
);

    fifo_req_t     req;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          wr_go;
    logic          rd_go;

    always_comb begin
        req.wr = wr_en;
        req.rd = rd_en;
        req.rt = rt_req;
    end

    rtfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .empty  (empty),
        .full   (full),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .wr_go  (wr_go),
        .rd_go  (rd_go),
        .rt_err (rt_err)
    );

    rtfifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .empty     (empty),
        .full      (full),
        .half_full (half_full)
    );

    rtfifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk   (clk),
        .we    (wr_go),
        .waddr (wr_ptr[AW-1:0]),
        .wdata (wr_data),
        .re    (rd_go),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_go;
        end
    end

    // R10
    rd_valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en && !empty && !rt_req));

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        $past(rst) |-> (empty && !full && !half_full && !rd_valid));

endmodule

// File: tb/test_rt_fifo.sv
`timescale 1ns/1ps
module test_rt_fifo;

    localparam int unsigned TB_DEPTH = 16;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic       rt;
        logic [8:0] din;
        logic       ev;
        logic [8:0] edat;
        logic       ee;
        logic       ef;
        logic       eh;
        logic       eerr;
    } vec_t;

    // wr rd rt din | valid data empty full half err
    localparam vec_t TBL [14] = '{
        '{1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 idle
        '{1'b1, 1'b0, 1'b0, 9'h1A5, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
        '{1'b1, 1'b0, 1'b0, 9'h003, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
        '{1'b0, 1'b1, 1'b0, 9'h000, 1'b1, 9'h1A5, 1'b0, 1'b0, 1'b0, 1'b0}, // R10
        '{1'b0, 1'b0, 1'b1, 9'h000, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
        '{1'b0, 1'b1, 1'b0, 9'h000, 1'b1, 9'h1A5, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
        '{1'b0, 1'b1, 1'b0, 9'h000, 1'b1, 9'h003, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
        '{1'b0, 1'b1, 1'b0, 9'h000, 1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0}, // R3
        '{1'b1, 1'b0, 1'b1, 9'h077, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
        '{1'b1, 1'b1, 1'b1, 9'h0AA, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
        '{1'b0, 1'b1, 1'b0, 9'h000, 1'b1, 9'h1A5, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
        '{1'b0, 1'b1, 1'b0, 9'h000, 1'b1, 9'h003, 1'b1, 1'b0, 1'b0, 1'b0}, // R9
        '{1'b1, 1'b1, 1'b0, 9'h0F0, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
        '{1'b0, 1'b1, 1'b0, 9'h000, 1'b1, 9'h0F0, 1'b1, 1'b0, 1'b0, 1'b0}  // R10
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       rt_req = 1'b0;
    logic [8:0] rd_data;
    logic       rd_valid;
    logic       empty;
    logic       full;
    logic       half_full;
    logic       rt_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rt_fifo #(.DEPTH(TB_DEPTH), .WIDTH(9)) i_rt_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rt_req    (rt_req),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .empty     (empty),
        .full      (full),
        .half_full (half_full),
        .rt_err    (rt_err)
    );

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic cyc(input logic w, input logic r, input logic t, input logic [8:0] d);
        wr_en   = w;
        rd_en   = r;
        rt_req  = t;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en  = 1'b0;
        rd_en  = 1'b0;
        rt_req = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 empty in reset", {8'd0, empty}, 9'd1);
        chk("R1 full in reset", {8'd0, full}, 9'd0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 empty after reset", {8'd0, empty}, 9'd1);
        chk("R1 half after reset", {8'd0, half_full}, 9'd0);
        chk("R1 valid after reset", {8'd0, rd_valid}, 9'd0);
        chk("R1 rt_err after reset", {8'd0, rt_err}, 9'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Table of vectors
        for (int k = 0; k < 14; k++) begin
            cyc(TBL[k].wr, TBL[k].rd, TBL[k].rt, TBL[k].din);
            chk($sformatf("R10 row %0d valid", k), {8'd0, rd_valid}, {8'd0, TBL[k].ev});
            if (TBL[k].ev) begin
                chk($sformatf("R10 row %0d data", k), rd_data, TBL[k].edat);
            end
            chk($sformatf("R4 row %0d empty", k), {8'd0, empty}, {8'd0, TBL[k].ee});
            chk($sformatf("R5 row %0d full", k), {8'd0, full}, {8'd0, TBL[k].ef});
            chk($sformatf("R6 row %0d half", k), {8'd0, half_full}, {8'd0, TBL[k].eh});
            chk($sformatf("R8 row %0d rt_err", k), {8'd0, rt_err}, {8'd0, TBL[k].eerr});
        end

        // Fill to full from reset
        do_reset();
        for (int i = 0; i < TB_DEPTH; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 9'h100 | 9'(i));
            chk($sformatf("R5 full after write %0d", i + 1), {8'd0, full},
                {8'd0, (i == TB_DEPTH - 1)});
            chk($sformatf("R6 half after write %0d", i + 1), {8'd0, half_full},
                {8'd0, (i >= TB_DEPTH / 2)});
        end

        // Write while full is ignored
        cyc(1'b1, 1'b0, 1'b0, 9'h1FF);
        chk("R2 full held", {8'd0, full}, 9'd1);

        // Drain in order; 0x1FF must not appear
        for (int i = 0; i < TB_DEPTH; i++) begin
            cyc(1'b0, 1'b1, 1'b0, 9'h000);
            chk($sformatf("R10 drain data %0d", i), rd_data, 9'h100 | 9'(i));
            chk($sformatf("R6 half after read %0d", i + 1), {8'd0, half_full},
                {8'd0, (i < TB_DEPTH / 2 - 1)});
            chk($sformatf("R4 empty after read %0d", i + 1), {8'd0, empty},
                {8'd0, (i == TB_DEPTH - 1)});
        end
        chk("R2 no extra word", {8'd0, empty}, 9'd1);

        // Rewind after exactly DEPTH writes: whole store replays
        cyc(1'b0, 1'b0, 1'b1, 9'h000);
        chk("R7 full after rewind", {8'd0, full}, 9'd1);
        chk("R7 rt_err clear", {8'd0, rt_err}, 9'd0);
        cyc(1'b0, 1'b1, 1'b0, 9'h000);
        chk("R7 first word replayed", rd_data, 9'h100);

        // One more write makes DEPTH+1 writes since reset
        cyc(1'b1, 1'b0, 1'b0, 9'h055);
        chk("R5 full again", {8'd0, full}, 9'd1);
        cyc(1'b0, 1'b1, 1'b0, 9'h000);
        chk("R10 second word", rd_data, 9'h101);

        // Rewind now refused
        cyc(1'b0, 1'b0, 1'b1, 9'h000);
        chk("R8 rt_err pulse", {8'd0, rt_err}, 9'd1);
        chk("R8 full unchanged", {8'd0, full}, 9'd0);
        chk("R8 half unchanged", {8'd0, half_full}, 9'd1);
        cyc(1'b0, 1'b1, 1'b0, 9'h000);
        chk("R8 read position kept", rd_data, 9'h102);
        chk("R8 rt_err one cycle", {8'd0, rt_err}, 9'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule